// File: doc/BRIEF.md
# Privilege-Checked Data Cache Hit Stage

This block is the last stage of a multi-threaded load/store pipeline with a set-associative first-level data cache. Each cycle it takes one request: a load, store or flush from a core thread, or a line update or replacement from the cache controller. The tags and the read/write permission bits of every way in the addressed set arrive with the request. Tag storage and arbitration sit in an earlier stage. This stage holds the data lines in a byte-enabled array.

For core requests it finds the matching way and decides on a load hit, load miss, store hit or store miss. The decision uses the two permission bits of each line, not a coherence state. A load hit returns the line towards writeback. A store hit merges the enabled bytes into the line and produces no output. A miss raises a miss flag for the controller and a one-cycle sleep pulse for the thread that issued the request.

Controller updates overwrite a whole line. A replacement also returns the previous contents and address of the line, so the controller can write it back. A separate snoop read port gives the controller data that already includes any write made to the same line in the same cycle. Every output is registered, so each result appears exactly one cycle after its request.

Top module: `dcache_hit_stage`

## Requirements
- R1: A way matches only when three conditions hold: its tag (way w at bits [w*TAG_W +: TAG_W] of `set_tags`) equals `req_tag`, it has `set_can_read[w]` or `set_can_write[w]`, and a core request is live. A live request means `req_valid` is high and `upd_valid` is low. A request whose tag matches a way that has no permission is a miss.
- R2: A load hits only when the matched way has read permission. A load to a way that has only write permission is a load miss.
- R3: A store hits only when the matched way has write permission. A store to a read-only line is a store miss and leaves the line unchanged.
- R4: A store hit writes only the bytes whose `req_byte_en` bit is set (bit b covers line bits [8b+7:8b]) into the matched line. It raises none of `ld_valid`, `miss`, `evict_valid` or `flush_valid`.
- R5: A load hit raises `ld_valid` one cycle later, with `ld_line` holding the line and `ld_thread` holding the issuing thread.
- R6: Any load or store miss raises `miss` one cycle later. In the same cycle it raises `sleep_pulse` with only bit `req_thread` set. Both clear on the following cycle unless another miss arrives.
- R7: An update (`upd_valid` high, `upd_evict` low) writes the whole `req_data` line at set `req_index`, way `upd_way`. It raises no output valid.
- R8: A replacement (`upd_valid` and `upd_evict` high) writes the new line at set `req_index`, way `upd_way`. One cycle later it raises `evict_valid`, with `ctl_line` holding the previous line, `ctl_tag` holding the tag of way `upd_way` from `set_tags`, and `ctl_index` holding `req_index`.
- R9: A flush request raises `flush_valid` one cycle later only when it hits and `write_through` is low. It then reports the line on `ctl_line`, `ctl_tag` and `ctl_index`. Otherwise a flush produces no output, including no miss.
- R10: A snoop (`snp_en`) returns the line at `snp_index`/`snp_way` on `snp_line` with `snp_valid` one cycle later. Bytes written to that same line in the snoop's cycle are returned with their new values.
- R11: After reset all valid outputs and `sleep_pulse` are low. Each result appears exactly one cycle after its request, and at most one of `ld_valid`, `miss`, `evict_valid` and `flush_valid` is high in any cycle.
- R12: While `upd_valid` is high, a core request presented in the same cycle is ignored: it neither writes nor produces a load, miss or flush result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_is_load | input | 1 | 1 = load, 0 = store |
| req_is_flush | input | 1 | Request is a flush |
| req_thread | input | TID_W | Issuing thread |
| req_tag | input | TAG_W | Request tag |
| req_index | input | IDX_W | Set index (core and controller) |
| req_data | input | LINE_W | Store data or new controller line |
| req_byte_en | input | LINE_BYTES | Store byte enables |
| set_tags | input | NUM_WAYS*TAG_W | Tags of the addressed set |
| set_can_read | input | NUM_WAYS | Read permission per way |
| set_can_write | input | NUM_WAYS | Write permission per way |
| upd_valid | input | 1 | Controller line write |
| upd_evict | input | 1 | Controller write is a replacement |
| upd_way | input | WAY_W | Way for controller write |
| write_through | input | 1 | Cache is in write-through mode |
| snp_en | input | 1 | Snoop read request |
| snp_index | input | IDX_W | Snoop set |
| snp_way | input | WAY_W | Snoop way |
| ld_valid | output | 1 | Load hit result valid |
| ld_thread | output | TID_W | Thread of load result |
| ld_line | output | LINE_W | Load hit line |
| miss | output | 1 | Load or store miss |
| sleep_pulse | output | NUM_THREADS | One-cycle sleep request per thread |
| evict_valid | output | 1 | Replacement victim reported |
| flush_valid | output | 1 | Flushed line reported |
| ctl_tag | output | TAG_W | Tag of reported line |
| ctl_index | output | IDX_W | Set of reported line |
| ctl_line | output | LINE_W | Contents of reported line |
| snp_valid | output | 1 | Snoop data valid |
| snp_line | output | LINE_W | Snoop data |

## Verification
The bench sets up permission combinations where the tag matches but the access must still miss: a line with no permission, a load to a write-only line, and a store to a read-only line. A design that decides hits on the tag alone would return data or corrupt the line in these cases. It applies a partial byte-enable store and reads the line back, which exposes a store that writes the whole line or the wrong bytes. It checks that a replacement reports the old contents under the old tag. A design that reads after writing would return the new line instead. It also issues a snoop in the same cycle as a write to that line. A read-first snoop port would return stale data. Flushes are tried with write-through set and on a miss, where a loose design would report a line or raise a spurious miss.

// File: rtl/dhs_pkg.sv
// Package: shared access classification for the data cache hit stage.
// Assumes: each cycle carries at most one classified access.
package dhs_pkg;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_LD_HIT,
        ACC_LD_MISS,
        ACC_ST_HIT,
        ACC_ST_MISS,
        ACC_FLUSH,
        ACC_UPDATE,
        ACC_REPLACE
    } acc_kind_e;

    // Returns true for either kind of miss.
    function automatic logic is_miss_kind(acc_kind_e k);
        return (k == ACC_LD_MISS) || (k == ACC_ST_MISS);
    endfunction

endpackage

// File: rtl/dhs_hit_detect.sv
// Module: dhs_hit_detect
// Compares the request tag against every way of the addressed set. A way
// needs at least one permission to match. Returns the matched way (lowest
// index first) and its permissions.
// Assumes: at most one way holds a given tag with permission.
module dhs_hit_detect #(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 8,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                      live,
    input  logic [TAG_W-1:0]          tag,
    input  logic [NUM_WAYS*TAG_W-1:0] way_tags,
    input  logic [NUM_WAYS-1:0]       can_rd,
    input  logic [NUM_WAYS-1:0]       can_wr,
    output logic                      hit,
    output logic [WAY_W-1:0]          hit_way,
    output logic                      hit_rd,
    output logic                      hit_wr
);

    logic [NUM_WAYS-1:0] match;

    // Per-way match: tag compare, some permission, live request.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign match[w] = live && (way_tags[w*TAG_W +: TAG_W] == tag)
                          && (can_rd[w] || can_wr[w]);
    end

    // Encode the one-hot match vector, lowest way first.
    always_comb begin
        hit_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit    = |match;
    assign hit_rd = can_rd[hit_way];
    assign hit_wr = can_wr[hit_way];

endmodule

// File: rtl/dhs_data_array.sv
// Module: dhs_data_array
// Byte-enabled line storage with one write port, one plain read port and
// one snoop read port. The snoop port forwards bytes written in the same
// cycle (write-first); the plain port returns the stored value.
// Assumes: NUM_WAYS is a power of two; reads are combinational.
module dhs_data_array #(
    parameter int NUM_SETS   = 8,
    parameter int NUM_WAYS   = 4,
    parameter int LINE_BYTES = 8,
    localparam int IDX_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int ENT_W     = IDX_W + WAY_W,
    localparam int ENTRIES   = 1 << ENT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LINE_BYTES-1:0] wr_be,
    input  logic [IDX_W-1:0]      wr_set,
    input  logic [WAY_W-1:0]      wr_way,
    input  logic [LINE_W-1:0]     wr_line,
    input  logic [IDX_W-1:0]      rd_set,
    input  logic [WAY_W-1:0]      rd_way,
    output logic [LINE_W-1:0]     rd_line,
    input  logic [IDX_W-1:0]      sn_set,
    input  logic [WAY_W-1:0]      sn_way,
    output logic [LINE_W-1:0]     sn_line
);

    logic [LINE_W-1:0] mem [ENTRIES];
    logic [ENT_W-1:0]  wr_ent, rd_ent, sn_ent;

    assign wr_ent = {wr_set, wr_way};
    assign rd_ent = {rd_set, rd_way};
    assign sn_ent = {sn_set, sn_way};

    // Line storage: clear on reset, byte-masked write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
        end else begin
            for (int b = 0; b < LINE_BYTES; b++) begin
                if (wr_be[b]) mem[wr_ent][b*8 +: 8] <= wr_line[b*8 +: 8];
            end
        end
    end

    assign rd_line = mem[rd_ent];

    // Snoop read: per-byte forwarding of a same-cycle write to the same line.
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_fwd
        assign sn_line[b*8 +: 8] = (wr_be[b] && (wr_ent == sn_ent))
                                   ? wr_line[b*8 +: 8] : mem[sn_ent][b*8 +: 8];
    end

endmodule

// File: rtl/dcache_hit_stage.sv
// Module: dcache_hit_stage
// Final data cache stage. Classifies core accesses by tag match and per-line
// read/write permission, applies controller updates and replacements, and
// serves write-first snoop reads. All results are registered: latency one.
// Assumes: set_tags/permissions belong to set req_index; a controller write
// wins over a core request in the same cycle.
module dcache_hit_stage
    import dhs_pkg::*;
#(
    parameter int NUM_WAYS    = 4,
    parameter int NUM_SETS    = 8,
    parameter int TAG_W       = 8,
    parameter int LINE_BYTES  = 8,
    parameter int NUM_THREADS = 4,
    localparam int IDX_W      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int LINE_W     = LINE_BYTES * 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_is_load,
    input  logic                      req_is_flush,
    input  logic [TID_W-1:0]          req_thread,
    input  logic [TAG_W-1:0]          req_tag,
    input  logic [IDX_W-1:0]          req_index,
    input  logic [LINE_W-1:0]         req_data,
    input  logic [LINE_BYTES-1:0]     req_byte_en,
    input  logic [NUM_WAYS*TAG_W-1:0] set_tags,
    input  logic [NUM_WAYS-1:0]       set_can_read,
    input  logic [NUM_WAYS-1:0]       set_can_write,
    input  logic                      upd_valid,
    input  logic                      upd_evict,
    input  logic [WAY_W-1:0]          upd_way,
    input  logic                      write_through,
    input  logic                      snp_en,
    input  logic [IDX_W-1:0]          snp_index,
    input  logic [WAY_W-1:0]          snp_way,
    output logic                      ld_valid,
    output logic [TID_W-1:0]          ld_thread,
    output logic [LINE_W-1:0]         ld_line,
    output logic                      miss,
    output logic [NUM_THREADS-1:0]    sleep_pulse,
    output logic                      evict_valid,
    output logic                      flush_valid,
    output logic [TAG_W-1:0]          ctl_tag,
    output logic [IDX_W-1:0]          ctl_index,
    output logic [LINE_W-1:0]         ctl_line,
    output logic                      snp_valid,
    output logic [LINE_W-1:0]         snp_line
);

    logic              live;
    logic              hit, hit_rd, hit_wr;
    logic [WAY_W-1:0]  hit_way;
    acc_kind_e         kind;
    logic [LINE_BYTES-1:0] wr_be;
    logic [WAY_W-1:0]  acc_way;
    logic [LINE_W-1:0] rd_line, sn_line;
    logic [TAG_W-1:0]  victim_tag;
    logic [NUM_THREADS-1:0] sleep_d;

    // A core request is live only when no controller write competes.
    assign live = req_valid && !upd_valid;

    dhs_hit_detect #(
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W)
    ) hit_i (
        .live     (live),
        .tag      (req_tag),
        .way_tags (set_tags),
        .can_rd   (set_can_read),
        .can_wr   (set_can_write),
        .hit      (hit),
        .hit_way  (hit_way),
        .hit_rd   (hit_rd),
        .hit_wr   (hit_wr)
    );

    // Classify this cycle's access.
    always_comb begin
        kind = ACC_IDLE;
        if (upd_valid) begin
            kind = upd_evict ? ACC_REPLACE : ACC_UPDATE;
        end else if (req_valid) begin
            if (req_is_flush) begin
                kind = (hit && !write_through) ? ACC_FLUSH : ACC_IDLE;
            end else if (req_is_load) begin
                kind = (hit && hit_rd) ? ACC_LD_HIT : ACC_LD_MISS;
            end else begin
                kind = (hit && hit_wr) ? ACC_ST_HIT : ACC_ST_MISS;
            end
        end
    end

    // Select way and byte enables for the data array access.
    always_comb begin
        acc_way = upd_valid ? upd_way : hit_way;
        case (kind)
            ACC_UPDATE, ACC_REPLACE: wr_be = '1;
            ACC_ST_HIT:              wr_be = req_byte_en;
            default:                 wr_be = '0;
        endcase
    end

    assign victim_tag = set_tags[int'(upd_way)*TAG_W +: TAG_W];

    dhs_data_array #(
        .NUM_SETS   (NUM_SETS),
        .NUM_WAYS   (NUM_WAYS),
        .LINE_BYTES (LINE_BYTES)
    ) data_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_be   (wr_be),
        .wr_set  (req_index),
        .wr_way  (acc_way),
        .wr_line (req_data),
        .rd_set  (req_index),
        .rd_way  (acc_way),
        .rd_line (rd_line),
        .sn_set  (snp_index),
        .sn_way  (snp_way),
        .sn_line (sn_line)
    );

    // Per-thread sleep request on a miss.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_sleep
        assign sleep_d[t] = is_miss_kind(kind) && (req_thread == TID_W'(t));
    end

    // Result registers: one cycle of latency for every output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid    <= 1'b0;
            ld_thread   <= '0;
            ld_line     <= '0;
            miss        <= 1'b0;
            sleep_pulse <= '0;
            evict_valid <= 1'b0;
            flush_valid <= 1'b0;
            ctl_tag     <= '0;
            ctl_index   <= '0;
            ctl_line    <= '0;
            snp_valid   <= 1'b0;
            snp_line    <= '0;
        end else begin
            ld_valid    <= (kind == ACC_LD_HIT);
            miss        <= is_miss_kind(kind);
            sleep_pulse <= sleep_d;
            evict_valid <= (kind == ACC_REPLACE);
            flush_valid <= (kind == ACC_FLUSH);
            snp_valid   <= snp_en;
            if (kind == ACC_LD_HIT) begin
                ld_thread <= req_thread;
                ld_line   <= rd_line;
            end
            if (kind == ACC_REPLACE || kind == ACC_FLUSH) begin
                ctl_tag   <= (kind == ACC_REPLACE) ? victim_tag : req_tag;
                ctl_index <= req_index;
                ctl_line  <= rd_line;
            end
            if (snp_en) snp_line <= sn_line;
        end
    end

endmodule

// File: rtl/dhs_checker.sv
// Module: dhs_checker
// Temporal checks on the hit stage ports; bound to every dcache_hit_stage.
module dhs_checker #(
    parameter int NUM_THREADS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_is_load,
    input logic                   req_is_flush,
    input logic                   upd_valid,
    input logic                   upd_evict,
    input logic                   write_through,
    input logic                   snp_en,
    input logic                   ld_valid,
    input logic                   miss,
    input logic [NUM_THREADS-1:0] sleep_pulse,
    input logic                   evict_valid,
    input logic                   flush_valid,
    input logic                   snp_valid
);

    // R6: a miss wakes exactly one sleep bit; no sleep without a miss.
    a_r6_sleep_one_thread: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> $countones(sleep_pulse) == 1);
    a_r6_sleep_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !miss |-> sleep_pulse == '0);

    // R11: result kinds are exclusive.
    a_r11_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_valid, miss, evict_valid, flush_valid}));

    // R5: a live load yields a hit or a miss in the next cycle.
    a_r5_load_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !upd_valid && req_is_load && !req_is_flush) |=> (ld_valid || miss));

    // R7: a plain update is silent.
    a_r7_update_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_evict) |=> !(ld_valid || miss || evict_valid || flush_valid));

    // R8: a replacement always reports its victim.
    a_r8_evict_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_evict) |=> evict_valid);

    // R9: no flush result in write-through mode.
    a_r9_wt_blocks_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !upd_valid && req_is_flush && write_through) |=> !flush_valid);

    // R10: snoop data follows one cycle after the request.
    a_r10_snoop_latency: assert property (@(posedge clk) disable iff (!rst_n)
        snp_en |=> snp_valid);

endmodule

bind dcache_hit_stage dhs_checker #(.NUM_THREADS(NUM_THREADS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_is_load   (req_is_load),
    .req_is_flush  (req_is_flush),
    .upd_valid     (upd_valid),
    .upd_evict     (upd_evict),
    .write_through (write_through),
    .snp_en        (snp_en),
    .ld_valid      (ld_valid),
    .miss          (miss),
    .sleep_pulse   (sleep_pulse),
    .evict_valid   (evict_valid),
    .flush_valid   (flush_valid),
    .snp_valid     (snp_valid)
);

// File: tb/dcache_hit_stage_tb_top.sv
// Directed bench for dcache_hit_stage: one task per scenario.
module dcache_hit_stage_tb_top;

    localparam int NW = 4, NS = 8, TW = 8, LB = 8, NT = 4;
    localparam int LW = LB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_is_load = 0, req_is_flush = 0;
    logic [1:0]  req_thread = '0;
    logic [TW-1:0] req_tag = '0;
    logic [2:0]  req_index = '0;
    logic [LW-1:0] req_data = '0;
    logic [LB-1:0] req_byte_en = '0;
    logic [NW*TW-1:0] set_tags = '0;
    logic [NW-1:0] set_can_read = '0, set_can_write = '0;
    logic upd_valid = 0, upd_evict = 0;
    logic [1:0] upd_way = '0;
    logic write_through = 0;
    logic snp_en = 0;
    logic [2:0] snp_index = '0;
    logic [1:0] snp_way = '0;
    logic ld_valid, miss, evict_valid, flush_valid, snp_valid;
    logic [1:0] ld_thread;
    logic [LW-1:0] ld_line, ctl_line, snp_line;
    logic [NT-1:0] sleep_pulse;
    logic [TW-1:0] ctl_tag;
    logic [2:0] ctl_index;

    int n_chk = 0, n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dcache_hit_stage dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_load(req_is_load),
        .req_is_flush(req_is_flush), .req_thread(req_thread), .req_tag(req_tag),
        .req_index(req_index), .req_data(req_data), .req_byte_en(req_byte_en),
        .set_tags(set_tags), .set_can_read(set_can_read), .set_can_write(set_can_write),
        .upd_valid(upd_valid), .upd_evict(upd_evict), .upd_way(upd_way),
        .write_through(write_through), .snp_en(snp_en), .snp_index(snp_index),
        .snp_way(snp_way), .ld_valid(ld_valid), .ld_thread(ld_thread), .ld_line(ld_line),
        .miss(miss), .sleep_pulse(sleep_pulse), .evict_valid(evict_valid),
        .flush_valid(flush_valid), .ctl_tag(ctl_tag), .ctl_index(ctl_index),
        .ctl_line(ctl_line), .snp_valid(snp_valid), .snp_line(snp_line)
    );

    task automatic check(string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Checks the four result flags together as {ld_valid,miss,evict,flush}.
    task automatic check_flags(string req, logic [3:0] exp);
        check(req, "flags", LW'({ld_valid, miss, evict_valid, flush_valid}), LW'(exp));
    endtask

    task automatic idle();
        req_valid = 0; req_is_load = 0; req_is_flush = 0; req_byte_en = '0;
        upd_valid = 0; upd_evict = 0; snp_en = 0;
    endtask

    // Drive at a falling edge, wait for the registered result one cycle on.
    task automatic step();
        @(negedge clk);
    endtask

    // Way 1 of set 2 carries the given tag and permissions; others unused.
    task automatic set_way1(logic [TW-1:0] t, logic rd, logic wr);
        set_tags = {8'h00, 8'h00, t, 8'h00};
        set_can_read = {2'b00, rd, 1'b0};
        set_can_write = {2'b00, wr, 1'b0};
    endtask

    task automatic core(logic ld, logic fl, logic [1:0] th, logic [TW-1:0] t,
                        logic [LW-1:0] d, logic [LB-1:0] be);
        req_valid = 1; req_is_load = ld; req_is_flush = fl; req_thread = th;
        req_tag = t; req_index = 3'd2; req_data = d; req_byte_en = be;
        step();
        idle();
    endtask

    task automatic t_reset();
        check_flags("R11", 4'b0000);
        check("R11", "sleep", LW'(sleep_pulse), '0);
        check("R11", "snp_valid", LW'(snp_valid), '0);
    endtask

    task automatic t_update_then_load();
        upd_valid = 1; upd_way = 2'd1; req_index = 3'd2; req_data = 64'h1122334455667788;
        req_valid = 1; req_is_load = 0; req_tag = 8'h5A; req_byte_en = '1;
        set_way1(8'h5A, 1, 1);
        step();
        check_flags("R7", 4'b0000);
        check_flags("R12", 4'b0000);
        idle();
        core(1, 0, 2'd3, 8'h5A, '0, '0);
        check_flags("R5", 4'b1000);
        check("R5", "ld_line", ld_line, 64'h1122334455667788);
        check("R5", "ld_thread", LW'(ld_thread), LW'(3));
    endtask

    task automatic t_store_hit();
        core(0, 0, 2'd1, 8'h5A, 64'hAAAAAAAAAAAAAAAA, 8'h0F);
        check_flags("R4", 4'b0000);
        core(1, 0, 2'd1, 8'h5A, '0, '0);
        check("R4", "merged line", ld_line, 64'h11223344AAAAAAAA);
    endtask

    task automatic t_store_readonly();
        set_way1(8'h5A, 1, 0);
        core(0, 0, 2'd2, 8'h5A, 64'hFFFFFFFFFFFFFFFF, 8'hFF);
        check_flags("R3", 4'b0100);
        check("R6", "sleep", LW'(sleep_pulse), LW'(4'b0100));
        step();
        check("R6", "sleep clears", LW'(sleep_pulse), '0);
        core(1, 0, 2'd0, 8'h5A, '0, '0);
        check("R3", "line unchanged", ld_line, 64'h11223344AAAAAAAA);
    endtask

    task automatic t_load_writeonly();
        set_way1(8'h5A, 0, 1);
        core(1, 0, 2'd0, 8'h5A, '0, '0);
        check_flags("R2", 4'b0100);
        check("R6", "sleep t0", LW'(sleep_pulse), LW'(4'b0001));
    endtask

    task automatic t_no_priv();
        set_way1(8'h5A, 0, 0);
        core(1, 0, 2'd1, 8'h5A, '0, '0);
        check_flags("R1", 4'b0100);
        set_way1(8'h5A, 1, 1);
        core(1, 0, 2'd1, 8'h77, '0, '0);
        check_flags("R1", 4'b0100);
    endtask

    task automatic t_replace();
        set_way1(8'h5A, 1, 1);
        upd_valid = 1; upd_evict = 1; upd_way = 2'd1; req_index = 3'd2;
        req_data = 64'h0123456789ABCDEF;
        step();
        idle();
        check_flags("R8", 4'b0010);
        check("R8", "old line", ctl_line, 64'h11223344AAAAAAAA);
        check("R8", "old tag", LW'(ctl_tag), LW'(8'h5A));
        check("R8", "index", LW'(ctl_index), LW'(2));
        set_way1(8'h3C, 1, 1);
        core(1, 0, 2'd2, 8'h3C, '0, '0);
        check("R8", "new line", ld_line, 64'h0123456789ABCDEF);
    endtask

    task automatic t_flush();
        write_through = 0;
        core(0, 1, 2'd0, 8'h3C, '0, '0);
        check_flags("R9", 4'b0001);
        check("R9", "line", ctl_line, 64'h0123456789ABCDEF);
        check("R9", "tag", LW'(ctl_tag), LW'(8'h3C));
        write_through = 1;
        core(0, 1, 2'd0, 8'h3C, '0, '0);
        check_flags("R9", 4'b0000);
        write_through = 0;
        core(0, 1, 2'd0, 8'h99, '0, '0);
        check_flags("R9", 4'b0000);
    endtask

    task automatic t_snoop();
        upd_valid = 1; upd_way = 2'd0; req_index = 3'd5; req_data = 64'hCAFEF00DDEADBEEF;
        snp_en = 1; snp_index = 3'd5; snp_way = 2'd0;
        step();
        idle();
        check("R10", "valid", LW'(snp_valid), LW'(1));
        check("R10", "write-first", snp_line, 64'hCAFEF00DDEADBEEF);
        snp_en = 1; snp_index = 3'd2; snp_way = 2'd1;
        step();
        idle();
        check("R10", "other line", snp_line, 64'h0123456789ABCDEF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        t_reset();
        t_update_then_load();
        t_store_hit();
        t_store_readonly();
        t_load_writeonly();
        t_no_priv();
        t_replace();
        t_flush();
        t_snoop();
        step();
        finish_run();
    end

endmodule